// File: doc/BRIEF.md
# Overlapping 11101 Serial Pattern Detector

This block watches a single-bit serial stream, one bit per clock, and raises its output in the very cycle that the most recent five bits, oldest first, read 1, 1, 1, 0, 1. It is a Mealy machine, so the flag depends on both the stored progress and the bit currently on the input. No extra latency is added: the flag comes up in the cycle that the final 1 is presented.

Matches may overlap. When a match completes, the trailing 1 becomes the first bit of the next candidate rather than being thrown away. The progress is held in a 3-bit state register with a fixed binary encoding: 000 means no progress, 001 means one 1 seen, 010 means two 1s seen, 011 means three or more 1s seen, and 100 means 1110 seen. A synchronous active-high reset clears the progress. The three encodings that are not used fall back to 000 on the next clock.

Top module: `p11101_det`

## Requirements
- R1: While `rst` is high at a rising edge, the state returns to no progress (000). In the first cycle after reset, `zOut` is 0 even when `xIn` is 1.
- R2: `zOut` is 1 exactly when the current `xIn` together with the previous four bits accepted since reset (oldest first) equals 1,1,1,0,1. Bits before reset count as 0.
- R3: Matches overlap. After a match, the input 1,1,0,1 completes a second match, because the final 1 of the first match is kept as a first 1.
- R4: `zOut` is a same-cycle function of `xIn`. In the state where 1110 has been seen, changing `xIn` inside one clock period moves `zOut` from 0 to 1 without waiting for an edge.
- R5: A run of more than three 1s followed by 0,1 still produces a match, for example 1,1,1,1,1,0,1.
- R6: A 0 that arrives after 1110 discards all progress. The input 1,1,1,0,0,1,1,0,1 gives no match on its last bit.
- R7: A reset in the middle of a stream discards partial progress. After 1,1,1,0 and a reset, an input of 1 gives `zOut` = 0.
- R8: The 20-bit stream 11101110111110111010 (first bit on the left) produces the output stream 00001000100000100010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset to no progress |
| xIn | input | 1 | Serial data bit for the current cycle |
| zOut | output | 1 | Mealy match flag for the current cycle |

## Verification
The fixed 20-bit stream is run first. It has overlapping matches and a long run of 1s, so it tells an overlap-keeping machine apart from one that restarts after each match. Short directed streams then target single transitions: a 0 right after 1110, more than three 1s in a row, and a reset in the middle of a pattern. These separate a correct machine from one that keeps stale progress. A same-cycle toggle of the input in the 1110 state shows whether the output is a true Mealy output or a registered one. Long random streams weighted toward 1s are checked bit by bit against a five-bit shift-history model, which covers the remaining transitions.

// File: rtl/p11101_pkg.sv
package p11101_pkg;

  localparam int StateW = 3;

  localparam logic [StateW-1:0] StIdle  = 3'b000;
  localparam logic [StateW-1:0] StOne   = 3'b001;
  localparam logic [StateW-1:0] StTwo   = 3'b010;
  localparam logic [StateW-1:0] StThree = 3'b011;
  localparam logic [StateW-1:0] StTail  = 3'b100;

  typedef struct packed {
    logic tailArmed;
  } ctrlStrobe_t;

endpackage

// File: rtl/p11101_ctrl.sv
module p11101_ctrl
  import p11101_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              xIn,
  output ctrlStrobe_t       strobe,
  output logic [StateW-1:0] curState
);

  logic [StateW-1:0] nextState;
  logic              legal;
  logic              d2, d1, d0;

  always_comb begin
    legal = !(curState[2] && (curState[1] || curState[0]));
    d2 = curState[1] && curState[0] && !xIn;
    d1 = (curState[1] || curState[0]) && xIn;
    d0 = (!curState[0] || curState[1]) && xIn;
    nextState = legal ? {d2, d1, d0} : StIdle;
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= StIdle;
    else     curState <= nextState;
  end

  assign strobe.tailArmed = curState[2];

  // R1: a reset edge leaves the machine with no progress
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> curState == StIdle);

  // R2: only the five defined encodings are ever held
  a_r2_legal_encoding: assert property (@(posedge clk) disable iff (rst)
    curState <= StTail);

  // R3: a completed match keeps its last 1 as fresh progress
  a_r3_overlap_resume: assert property (@(posedge clk) disable iff (rst)
    (curState == StTail && xIn) |=> curState == StOne);

  // R5: extra 1s do not leave the three-ones state
  a_r5_hold_ones: assert property (@(posedge clk) disable iff (rst)
    (curState == StThree && xIn) |=> curState == StThree);

  // R6: a 0 after 1110 discards progress
  a_r6_tail_break: assert property (@(posedge clk) disable iff (rst)
    (curState == StTail && !xIn) |=> curState == StIdle);

endmodule

// File: rtl/p11101_dpath.sv
module p11101_dpath
  import p11101_pkg::*;
(
  input  logic        xIn,
  input  ctrlStrobe_t strobe,
  output logic        zOut
);

  assign zOut = xIn && strobe.tailArmed;

endmodule

// File: rtl/p11101_det.sv
module p11101_det
  import p11101_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic xIn,
  output logic zOut
);

  ctrlStrobe_t       strobe;
  logic [StateW-1:0] curState;

  p11101_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .xIn      (xIn),
    .strobe   (strobe),
    .curState (curState)
  );

  p11101_dpath dpath_i (
    .xIn    (xIn),
    .strobe (strobe),
    .zOut   (zOut)
  );

  // R2: the flag is raised only from the 1110 state
  a_r2_flag_only_in_tail: assert property (@(posedge clk) disable iff (rst)
    zOut |-> curState == StTail);

  // R4: in the 1110 state a 1 on the input raises the flag in the same cycle
  a_r4_same_cycle_flag: assert property (@(posedge clk) disable iff (rst)
    (curState == StTail && xIn) |-> zOut);

endmodule

// File: tb/p11101_det_tb.sv
module p11101_det_tb_top;

  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xIn = 1'b0;
  logic zOut;

  int nChecks = 0;
  int nFails  = 0;
  logic [3:0] hist = 4'b0000;
  bit finished = 1'b0;

  p11101_det dut_i (
    .clk  (clk),
    .rst  (rst),
    .xIn  (xIn),
    .zOut (zOut)
  );

  always #(ClkPeriod/2) clk = ~clk;

  task automatic check(input logic got, input logic exp, input string req);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: zOut=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic refZ(input logic b);
    return ({hist, b} == 5'b11101);
  endfunction

  task automatic sendBit(input logic b, input string req);
    @(negedge clk);
    xIn = b;
    #1;
    check(zOut, refZ(b), req);
    hist = {hist[2:0], b};
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    xIn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    hist = 4'b0000;
  endtask

  task automatic testReset();
    doReset();
    xIn = 1'b1;
    #1;
    check(zOut, 1'b0, "R1 reset state");
    hist = 4'b0001;
    sendBit(1'b0, "R1 after reset");
  endtask

  task automatic testExample();
    logic [19:0] inStream  = 20'b11101110111110111010;
    logic [19:0] outStream = 20'b00001000100000100010;
    doReset();
    for (int i = 19; i >= 0; i--) begin
      @(negedge clk);
      xIn = inStream[i];
      #1;
      check(zOut, outStream[i], "R8 example stream");
      check(zOut, refZ(inStream[i]), "R3 overlap model");
      hist = {hist[2:0], inStream[i]};
    end
  endtask

  task automatic testOnesRun();
    logic [6:0] s = 7'b1111101;
    doReset();
    for (int i = 6; i >= 0; i--) sendBit(s[i], "R5 long ones run");
    check(zOut, 1'b1, "R5 match after run");
  endtask

  task automatic testTailBreak();
    logic [8:0] s = 9'b111001101;
    doReset();
    for (int i = 8; i >= 0; i--) sendBit(s[i], "R6 break after tail");
    check(zOut, 1'b0, "R6 no match at end");
  endtask

  task automatic testResetMid();
    doReset();
    sendBit(1'b1, "R7 prefix");
    sendBit(1'b1, "R7 prefix");
    sendBit(1'b1, "R7 prefix");
    sendBit(1'b0, "R7 prefix");
    doReset();
    xIn = 1'b1;
    #1;
    check(zOut, 1'b0, "R7 progress discarded");
    hist = 4'b0001;
  endtask

  task automatic testMealy();
    doReset();
    sendBit(1'b1, "R4 prefix");
    sendBit(1'b1, "R4 prefix");
    sendBit(1'b1, "R4 prefix");
    sendBit(1'b0, "R4 prefix");
    @(negedge clk);
    xIn = 1'b0;
    #1;
    check(zOut, 1'b0, "R4 low input in tail state");
    xIn = 1'b1;
    #1;
    check(zOut, 1'b1, "R4 same-cycle rise");
    hist = {hist[2:0], 1'b1};
  endtask

  task automatic testRandom(input int nBits);
    doReset();
    for (int i = 0; i < nBits; i++) begin
      logic b;
      b = ($urandom_range(0, 3) != 0);
      sendBit(b, "R2 random stream");
    end
  endtask

  initial begin
    #(ClkPeriod * 150000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    testReset();
    testExample();
    testOnesRun();
    testTailBreak();
    testResetMid();
    testMealy();
    testRandom(3000);
    testRandom(3000);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule